// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames, byte by byte, from a receive FIFO and stores them into memory buffers that software describes with a ring of linked descriptors. Each descriptor occupies four consecutive 32-bit words. Word 0 is status, word 1 is control, word 2 is the buffer address and word 3 is the address of the next descriptor. Bit 31 of the status word grants the descriptor to hardware. The engine reads the descriptor and confirms that it owns it. It then streams one frame into the buffer, up to the capacity the control word allows. Finally it writes the status word back with ownership returned to software, the stored length, and error flags, and moves to the next descriptor.

Software points the engine at the first descriptor through a base input and raises a run level. A store-and-forward selection holds back every memory write for a frame until the FIFO reports that the complete frame is present. Without it, bytes are taken as soon as they arrive. When the engine finds a descriptor still held by software, it waits a fixed number of cycles and reads the same status word again. It never skips ahead.

Top module: `rx_desc_ring_dma`

## Requirements
- R1: While reset is applied and afterwards with run low, the engine issues no memory request and takes no FIFO byte.
- R2: When run rises from idle, the engine reads the descriptor at the base address in word order status, control, buffer, next (byte addresses base, base+4, base+8, base+12).
- R3: If status bit 31 reads 0, the engine reads no further words of that descriptor and takes no FIFO byte. It reads the same status word again after POLL_GAP cycles and keeps doing so until bit 31 reads 1.
- R4: When a frame ends, the engine writes status word 0 of the descriptor with bit 31 and bit 30 cleared and the stored byte count in bits 29:16. This write is issued after every buffer write for that frame.
- R5: Frame bytes are stored consecutively from the buffer address with its two low bits forced to zero. Byte k of the frame lands in byte lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of word k/4. A final partial word enables only its valid lanes.
- R6: Control bits 13:0 give the buffer capacity in bytes. Bytes past the capacity are taken from the FIFO and discarded, and no memory byte past the capacity is written. The stored length equals the capacity, and status bit 0 is set when any byte was dropped (otherwise it is 0).
- R7: Status bit 1 is set when the whole frame was shorter than 64 bytes and is 0 for frames of 64 bytes or more.
- R8: After the write-back, the engine continues at the address read from word 3. A ring whose last next pointer names the first descriptor is walked around indefinitely.
- R9: With store-and-forward selected (latched when the descriptor is read), no byte of a frame is taken and no buffer word is written until the FIFO signals that a complete frame is held.
- R10: With store-and-forward not selected, bytes are taken and buffer words written while the frame is still arriving.
- R11: When run falls, the engine finishes any frame in progress, then makes no further memory request. Raising run again restarts the walk from the current base address.
- R12: A memory request is held with unchanged address, direction, data and enables until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Run level; the walk starts at the base on its rise from idle |
| cfg_store_fwd | input | 1 | 1 selects store-and-forward, 0 selects cut-through |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | Head byte is the final byte of its frame |
| fifo_frame_ready | input | 1 | FIFO holds at least one complete frame |
| fifo_ready | output | 1 | Engine takes the head byte this cycle when fifo_valid is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest condition to reach from the ports is the store-and-forward hold. It requires a frame that is partly in the FIFO while a descriptor the engine already owns is waiting. The bench arms the descriptor and waits for the fetch to finish. It then feeds bytes with gaps between them and checks, just before the final byte, that nothing was taken and no buffer word was written. The polling path is reached in the same way. Bytes are queued while the current descriptor still belongs to software, and the bench confirms that they stay in the FIFO and that only that status word is re-read.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_BYTES = 4;
  localparam int OWN_BIT    = 31;
  localparam int LEN_LSB    = 16;
  localparam int STAT_LEN_W = 14;
  localparam int RUNT_BIT   = 1;
  localparam int TRUNC_BIT  = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_POLL,
    S_ARM,
    S_STREAM,
    S_FLUSH,
    S_WB
  } rxd_state_e;

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] word,
  output logic [BYTES-1:0]   be,
  output logic               full
);

  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [8*BYTES-1:0] word_q, word_d;

  always_comb begin
    cnt_d  = cnt_q;
    word_d = word_q;
    if (clr) begin
      cnt_d = '0;
    end else if (push) begin
      cnt_d = cnt_q + CW'(1);
      for (int i = 0; i < BYTES; i++) begin
        if (cnt_q == CW'(i)) word_d[8*i +: 8] = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      if (clr || push) cnt_q <= cnt_d;
      if (push)        word_q <= word_d;
    end
  end

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign be[g] = (cnt_q > CW'(g));
    end
  endgenerate

  assign word = word_q;
  assign full = (cnt_q == CW'(BYTES));

  p_pack_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && push));
  p_pack_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int TW = $clog2(GAP + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? TW'(GAP) : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == TW'(1));

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_store_fwd,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic          fifo_valid,
  input  logic          fifo_last,
  input  logic          fifo_frame_ready,
  output logic          fifo_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          pk_push,
  output logic          pk_clr,
  input  logic [31:0]   pk_word,
  input  logic [3:0]    pk_be,
  input  logic          pk_full,
  output logic          poll_start,
  input  logic          poll_done
);

  localparam int SEEN_W = $clog2(MIN_FRAME + 1);
  localparam logic [SEEN_W-1:0] SEEN_MAX = SEEN_W'(MIN_FRAME);

  rxd_state_e            st_q, st_d;
  logic [AW-1:0]         desc_q, desc_d;
  logic [AW-1:0]         buf_q, buf_d;
  logic [AW-1:0]         next_q, next_d;
  logic [1:0]            idx_q, idx_d;
  logic [STAT_LEN_W-1:0] cap_q, cap_d;
  logic [STAT_LEN_W-1:0] stored_q, stored_d;
  logic [SEEN_W-1:0]     seen_q, seen_d;
  logic                  trunc_q, trunc_d;
  logic                  sf_q, sf_d;

  logic                  take, keep, pk_any, runt;
  logic [31:0]           wb_word;

  assign pk_any = |pk_be;
  assign runt   = (seen_q < SEEN_MAX);

  always_comb begin
    wb_word = '0;
    wb_word[LEN_LSB +: STAT_LEN_W] = stored_q;
    wb_word[RUNT_BIT]  = runt;
    wb_word[TRUNC_BIT] = trunc_q;
  end

  // memory port and FIFO handshake
  always_comb begin
    fifo_ready = (st_q == S_STREAM) && !pk_full;
    take       = fifo_ready && fifo_valid;
    keep       = take && (stored_q < cap_q);
    pk_push    = keep;

    mem_req = 1'b0;
    case (st_q)
      S_RD_REQ: mem_req = 1'b1;
      S_WB:     mem_req = 1'b1;
      S_STREAM: mem_req = pk_full;
      S_FLUSH:  mem_req = pk_any;
      default:  mem_req = 1'b0;
    endcase

    mem_we    = (st_q != S_RD_REQ);
    mem_addr  = buf_q;
    mem_wdata = pk_word;
    mem_be    = pk_be;
    if (st_q == S_RD_REQ) begin
      mem_addr = desc_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
      mem_be   = 4'hf;
    end else if (st_q == S_WB) begin
      mem_addr  = desc_q;
      mem_wdata = wb_word;
      mem_be    = 4'hf;
    end

    pk_clr = ((st_q == S_STREAM) || (st_q == S_FLUSH)) && mem_req && mem_gnt;
  end

  // next state
  always_comb begin
    st_d       = st_q;
    desc_d     = desc_q;
    buf_d      = buf_q;
    next_d     = next_q;
    idx_d      = idx_q;
    cap_d      = cap_q;
    stored_d   = stored_q;
    seen_d     = seen_q;
    trunc_d    = trunc_q;
    sf_d       = sf_q;
    poll_start = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (cfg_run) begin
          desc_d = cfg_ring_base;
          idx_d  = 2'd0;
          st_d   = S_RD_REQ;
        end
      end
      S_RD_REQ: begin
        if (mem_gnt) st_d = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (mem_rvalid) begin
          case (idx_q)
            2'd0: begin
              if (!mem_rdata[OWN_BIT]) begin
                poll_start = 1'b1;
                st_d       = S_POLL;
              end else begin
                idx_d = 2'd1;
                st_d  = S_RD_REQ;
              end
            end
            2'd1: begin
              cap_d = mem_rdata[STAT_LEN_W-1:0];
              idx_d = 2'd2;
              st_d  = S_RD_REQ;
            end
            2'd2: begin
              buf_d = {mem_rdata[AW-1:2], 2'b00};
              idx_d = 2'd3;
              st_d  = S_RD_REQ;
            end
            default: begin
              next_d   = mem_rdata[AW-1:0];
              stored_d = '0;
              seen_d   = '0;
              trunc_d  = 1'b0;
              sf_d     = cfg_store_fwd;
              st_d     = S_ARM;
            end
          endcase
        end
      end
      S_POLL: begin
        if (!cfg_run) begin
          st_d = S_IDLE;
        end else if (poll_done) begin
          idx_d = 2'd0;
          st_d  = S_RD_REQ;
        end
      end
      S_ARM: begin
        if (sf_q ? fifo_frame_ready : fifo_valid) st_d = S_STREAM;
      end
      S_STREAM: begin
        if (take) begin
          if (seen_q != SEEN_MAX) seen_d = seen_q + SEEN_W'(1);
          if (keep) stored_d = stored_q + STAT_LEN_W'(1);
          else      trunc_d  = 1'b1;
          if (fifo_last) st_d = S_FLUSH;
        end
        if (mem_req && mem_gnt) buf_d = buf_q + AW'(WORD_BYTES);
      end
      S_FLUSH: begin
        if (!pk_any) begin
          st_d = S_WB;
        end else if (mem_gnt) begin
          buf_d = buf_q + AW'(WORD_BYTES);
          st_d  = S_WB;
        end
      end
      S_WB: begin
        if (mem_gnt) begin
          desc_d = next_q;
          idx_d  = 2'd0;
          st_d   = cfg_run ? S_RD_REQ : S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      desc_q   <= '0;
      buf_q    <= '0;
      next_q   <= '0;
      idx_q    <= '0;
      cap_q    <= '0;
      stored_q <= '0;
      seen_q   <= '0;
      trunc_q  <= 1'b0;
      sf_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      desc_q   <= desc_d;
      buf_q    <= buf_d;
      next_q   <= next_d;
      idx_q    <= idx_d;
      cap_q    <= cap_d;
      stored_q <= stored_d;
      seen_q   <= seen_d;
      trunc_q  <= trunc_d;
      sf_q     <= sf_d;
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));

  p_cap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STREAM) |-> (stored_q <= cap_q));

  p_sf_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && fifo_valid && sf_q) |-> fifo_frame_ready);

  p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD_WAIT && mem_rvalid && idx_q == 2'd0 && !mem_rdata[OWN_BIT])
      |=> (!mem_req && !fifo_ready));

  p_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

endmodule

// File: rtl/rx_desc_ring_dma.sv
module rx_desc_ring_dma #(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64,
  parameter int POLL_GAP  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_store_fwd,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic          fifo_valid,
  input  logic [7:0]    fifo_data,
  input  logic          fifo_last,
  input  logic          fifo_frame_ready,
  output logic          fifo_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);

  logic        pk_push, pk_clr, pk_full;
  logic [31:0] pk_word;
  logic [3:0]  pk_be;
  logic        poll_start, poll_done;

  rxd_packer #(.BYTES(rxd_pkg::WORD_BYTES)) u_packer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pk_clr),
    .push (pk_push),
    .din  (fifo_data),
    .word (pk_word),
    .be   (pk_be),
    .full (pk_full)
  );

  rxd_poll_timer #(.GAP(POLL_GAP)) u_poll (
    .clk  (clk),
    .rst_n(rst_n),
    .start(poll_start),
    .done (poll_done)
  );

  rxd_engine #(.AW(AW), .MIN_FRAME(MIN_FRAME)) u_engine (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_run         (cfg_run),
    .cfg_store_fwd   (cfg_store_fwd),
    .cfg_ring_base   (cfg_ring_base),
    .fifo_valid      (fifo_valid),
    .fifo_last       (fifo_last),
    .fifo_frame_ready(fifo_frame_ready),
    .fifo_ready      (fifo_ready),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_be          (mem_be),
    .mem_wdata       (mem_wdata),
    .mem_gnt         (mem_gnt),
    .mem_rvalid      (mem_rvalid),
    .mem_rdata       (mem_rdata),
    .pk_push         (pk_push),
    .pk_clr          (pk_clr),
    .pk_word         (pk_word),
    .pk_be           (pk_be),
    .pk_full         (pk_full),
    .poll_start      (poll_start),
    .poll_done       (poll_done)
  );

endmodule

// File: tb/tb_rx_desc_ring_dma.sv
module tb_rx_desc_ring_dma;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] RING = 32'h40;
  localparam logic [31:0] BUF0 = 32'h200;
  localparam int BUF_SPAN = 384;

  // {store_fwd, capacity[9:0], length[9:0]}
  localparam logic [20:0] VEC [0:7] = '{
    {1'b1, 10'd300, 10'd100},
    {1'b1, 10'd300, 10'd64},
    {1'b0, 10'd300, 10'd63},
    {1'b1, 10'd120, 10'd200},
    {1'b1, 10'd300, 10'd1},
    {1'b0, 10'd128, 10'd128},
    {1'b1, 10'd0,   10'd20},
    {1'b0, 10'd300, 10'd67}
  };

  logic          clk, rst_n;
  logic          cfg_run, cfg_store_fwd;
  logic [AW-1:0] cfg_ring_base;
  logic          fifo_valid, fifo_last, fifo_frame_ready, fifo_ready;
  logic [7:0]    fifo_data;
  logic          mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;

  rx_desc_ring_dma #(.AW(AW), .MIN_FRAME(64), .POLL_GAP(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_store_fwd(cfg_store_fwd),
    .cfg_ring_base(cfg_ring_base), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_frame_ready(fifo_frame_ready), .fifo_ready(fifo_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model
  logic [31:0] mem [0:511];
  logic [7:0]  gcnt;
  int          rd_total, buf_wr_total, req_cycles, hold_bad;
  logic [31:0] rd_hist [0:15];
  logic        pend_q;
  logic [31:0] pend_addr;

  assign mem_gnt = mem_req && (gcnt[1:0] != 2'd3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      rd_total <= 0; buf_wr_total <= 0; req_cycles <= 0; hold_bad <= 0;
      pend_q <= 1'b0; pend_addr <= '0;
    end else begin
      gcnt <= gcnt + 8'd1;
      mem_rvalid <= 1'b0;
      if (mem_req) req_cycles <= req_cycles + 1;
      if (pend_q && !(mem_req && mem_addr == pend_addr)) hold_bad <= hold_bad + 1;
      pend_q    <= mem_req && !mem_gnt;
      pend_addr <= mem_addr;
      if (mem_req && mem_gnt) begin
        if (!mem_we) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[10:2]];
          rd_hist[rd_total % 16] <= mem_addr;
          rd_total <= rd_total + 1;
        end else begin
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[10:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
          if (mem_addr >= BUF0) buf_wr_total <= buf_wr_total + 1;
        end
      end
    end
  end

  // FIFO model
  logic [7:0] fb [0:4095];
  logic       fl [0:4095];
  int wp, rp, frames_in, frames_out;

  assign fifo_valid       = (rp != wp);
  assign fifo_data        = fb[rp % 4096];
  assign fifo_last        = fl[rp % 4096];
  assign fifo_frame_ready = (frames_in != frames_out);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= 0; frames_out <= 0;
    end else if (fifo_ready && fifo_valid) begin
      rp <= rp + 1;
      if (fl[rp % 4096]) frames_out <= frames_out + 1;
    end
  end

  function automatic logic [7:0] fbyte(int id, int k);
    return 8'((id * 37 + k * 7 + 1) & 255);
  endfunction

  function automatic logic [31:0] daddr(int d);
    return RING + 32'(d * 16);
  endfunction

  function automatic logic [31:0] baddr(int d);
    return BUF0 + 32'(d * BUF_SPAN);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push_byte(logic [7:0] b, bit last);
    @(negedge clk);
    fb[wp % 4096] = b;
    fl[wp % 4096] = last;
    wp = wp + 1;
    if (last) frames_in = frames_in + 1;
  endtask

  task automatic push_frame(int id, int len, int gap);
    for (int k = 0; k < len; k++) begin
      push_byte(fbyte(id, k), k == len - 1);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic arm(int d, int cap, bit sf);
    @(negedge clk);
    cfg_store_fwd = sf;
    for (int w = 0; w < BUF_SPAN / 4; w++) mem[(baddr(d) >> 2) + w] = 32'hA5A5A5A5;
    mem[(daddr(d) >> 2) + 1] = 32'(cap);
    mem[(daddr(d) >> 2) + 2] = baddr(d) | 32'(d & 3);
    mem[(daddr(d) >> 2) + 3] = daddr((d + 1) % 4);
    mem[daddr(d) >> 2]       = 32'h8000_0000;
  endtask

  task automatic check_frame(int d, int id, int len, int cap);
    int n, stored, mism, gbad;
    logic [31:0] st, a;
    logic [7:0]  got;
    n = 0;
    while (mem[daddr(d) >> 2][31] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, "R8 descriptor completed", n, 0);
    stored = (len < cap) ? len : cap;
    st = mem[daddr(d) >> 2];
    chk(st[31:30] == 2'b00, "R4 ownership returned", st[31:30], 0);
    chk(st[29:16] == 14'(stored), "R4 length field", st[29:16], stored);
    chk(st[1] == (len < 64), "R7 runt flag", st[1], len < 64);
    chk(st[0] == (len > cap), "R6 truncation flag", st[0], len > cap);
    mism = 0;
    gbad = 0;
    for (int k = 0; k < BUF_SPAN; k++) begin
      a = baddr(d) + 32'(k);
      got = mem[a[10:2]][8*a[1:0] +: 8];
      if (k < stored) begin
        if (got != fbyte(id, k)) mism++;
      end else if (got != 8'hA5) gbad++;
    end
    chk(mism == 0, "R5 buffer contents", mism, 0);
    chk(gbad == 0, "R6 no write past stored length", gbad, 0);
  endtask

  initial begin
    int r0, p0, w0, lim;
    bit allsame;
    rst_n = 1'b0;
    cfg_run = 1'b0;
    cfg_store_fwd = 1'b1;
    cfg_ring_base = RING;
    wp = 0;
    frames_in = 0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int d = 0; d < 4; d++) mem[(daddr(d) >> 2) + 3] = daddr((d + 1) % 4);
    repeat (3) @(negedge clk);
    chk(!mem_req && !fifo_ready, "R1 idle during reset", {mem_req, fifo_ready}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!mem_req && !fifo_ready, "R1 idle after reset", {mem_req, fifo_ready}, 0);
    chk(req_cycles == 0, "R1 no request without run", req_cycles, 0);

    // R2: descriptor word order from base
    arm(0, 300, 1'b1);
    r0 = rd_total;
    cfg_run = 1'b1;
    lim = 0;
    while (rd_total < r0 + 4 && lim < 200) begin @(negedge clk); lim++; end
    for (int k = 0; k < 4; k++)
      chk(rd_hist[(r0 + k) % 16] == RING + 32'(4 * k), "R2 fetch order",
          rd_hist[(r0 + k) % 16], RING + 32'(4 * k));
    push_frame(50, 90, 0);
    check_frame(0, 50, 90, 300);

    // table of vectors walking the ring twice
    for (int i = 0; i < 8; i++) begin
      int d;
      d = (i + 1) % 4;
      arm(d, int'(VEC[i][19:10]), VEC[i][20]);
      push_frame(i, int'(VEC[i][9:0]), 0);
      check_frame(d, i, int'(VEC[i][9:0]), int'(VEC[i][19:10]));
    end

    // R3: software-owned descriptor holds off the FIFO, same word re-read
    push_frame(60, 70, 0);
    p0 = rp;
    r0 = rd_total;
    repeat (120) @(negedge clk);
    chk(rp == p0, "R3 no byte taken while not owned", rp - p0, 0);
    chk(rd_total - r0 >= 2, "R3 status re-read", rd_total - r0, 2);
    allsame = 1;
    for (int k = r0; k < rd_total && k < r0 + 16; k++)
      if (rd_hist[k % 16] != daddr(1)) allsame = 0;
    chk(allsame, "R8 ring wrapped to descriptor 1 status only", allsame, 1);
    arm(1, 300, 1'b1);
    check_frame(1, 60, 70, 300);

    // R9: store-and-forward hold with slow arrival
    arm(2, 300, 1'b1);
    repeat (40) @(negedge clk);
    p0 = rp;
    w0 = buf_wr_total;
    for (int k = 0; k < 79; k++) begin
      push_byte(fbyte(61, k), 1'b0);
      repeat (3) @(negedge clk);
    end
    chk(rp == p0, "R9 no byte taken before frame complete", rp - p0, 0);
    chk(buf_wr_total == w0, "R9 no buffer write before frame complete", buf_wr_total - w0, 0);
    push_byte(fbyte(61, 79), 1'b1);
    check_frame(2, 61, 80, 300);

    // R10: cut-through streams while arriving
    arm(3, 300, 1'b0);
    repeat (40) @(negedge clk);
    p0 = rp;
    w0 = buf_wr_total;
    for (int k = 0; k < 39; k++) begin
      push_byte(fbyte(62, k), 1'b0);
      repeat (3) @(negedge clk);
    end
    chk(rp - p0 >= 36, "R10 bytes taken during arrival", rp - p0, 36);
    chk(buf_wr_total - w0 >= 8, "R10 buffer writes during arrival", buf_wr_total - w0, 8);
    push_byte(fbyte(62, 39), 1'b1);
    check_frame(3, 62, 40, 300);

    // R11: stop and restart from a new base
    cfg_run = 1'b0;
    repeat (40) @(negedge clk);
    p0 = req_cycles;
    repeat (60) @(negedge clk);
    chk(req_cycles == p0, "R11 silent after stop", req_cycles - p0, 0);
    r0 = rd_total;
    cfg_ring_base = daddr(1);
    cfg_run = 1'b1;
    lim = 0;
    while (rd_total == r0 && lim < 200) begin @(negedge clk); lim++; end
    chk(rd_hist[r0 % 16] == daddr(1), "R11 restart at base", rd_hist[r0 % 16], daddr(1));

    chk(hold_bad == 0, "R12 request held until grant", hold_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule